// File: doc/BRIEF.md
# SDRAM Single-Word Read Sequencer

This block turns one read request into the complete command sequence a four-bank, 16-bit-wide synchronous DRAM needs in order to return one word. It takes a bank, a row and a column with a valid strobe. It opens the row, issues a column read with auto-precharge disabled, and captures the word from the data bus once the CAS latency has elapsed. It then closes the row with an explicit precharge. The precharge is held back until the minimum row-active time has passed since the row was opened.

All command, bank, address and mask pins come from flops, so the device sees clean, registered timing. The four device timing limits (activate-to-read, row-active minimum, precharge-to-activate, activate-to-activate) and the CAS latency are parameters counted in clock cycles. Each limit is enforced by its own counter. Device initialization, mode-register setup, refresh and writes are handled elsewhere. Clock enable stays high and the byte masks stay low.

Top module: `sdram_rd_seq`

## Requirements
- R1: While rst_ni is low and after reset, the command pins {cs_n_o, ras_n_o, cas_n_o, we_n_o} read 4'b0111 (no-operation), busy_o and done_o are low, cke_o is high and dqm_o is 2'b00.
- R2: A request accepted at a clock edge launches activate (4'b0011) at that same edge, with ba_o equal to the request bank and addr_o[11:0] equal to the request row.
- R3: Exactly T_RCD edges after activate, the block launches read (4'b0101) with ba_o equal to the bank, addr_o[7:0] equal to the column, and addr_o[11:8] low (so A10 = 0, no auto-precharge).
- R4: dq_i is captured at the edge CAS_LAT+1 edges after the read launch. done_o is high for exactly one cycle after that edge (T_RCD+CAS_LAT+1 edges after acceptance). rdata_o then holds the captured word until the next capture.
- R5: Precharge (4'b0010) is launched max(T_RCD+CAS_LAT+2, T_RAS) edges after activate, never sooner than T_RAS edges. It carries ba_o equal to the bank, and addr_o[10] equals the PRE_ALL parameter (0 = close this bank only, 1 = close all banks).
- R6: The next activate comes no sooner than T_RP edges after precharge and T_RC edges after the previous activate. With valid held high, activates repeat every max(T_RCD+CAS_LAT+2, T_RAS)+T_RP edges or every T_RC edges, whichever is larger (8 with defaults).
- R7: busy_o is high from the cycle after acceptance until the cycle before the next activate could be launched. A request seen while busy_o is high is ignored: no extra command is issued, and the pending result is unchanged.
- R8: Every cycle that carries no activate, read or precharge shows no-operation. No other command code ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, also the device clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request strobe, taken when busy_o is low |
| req_bank_i | input | 2 | Bank of the word to read |
| req_row_i | input | 12 | Row of the word to read |
| req_col_i | input | 8 | Column of the word to read |
| busy_o | output | 1 | High while a new request would be ignored |
| done_o | output | 1 | One-cycle pulse when rdata_o is updated |
| rdata_o | output | 16 | Last word read |
| cke_o | output | 1 | Device clock enable, held high |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 12 | Row, column and precharge-scope address |
| dqm_o | output | 2 | Byte masks, held low |
| dq_i | input | 16 | Data bus from the device |

## Verification
Every result has a fixed offset from the acceptance edge. Activate appears on that edge. Read follows T_RCD edges later and precharge max(T_RCD+CAS_LAT+2, T_RAS) edges later. done_o and the word show after T_RCD+CAS_LAT+1 edges, and busy_o falls in the cycle before the next activate slot. The bench drives inputs on falling edges and numbers each falling edge after the request. It checks each output only at the falling edge where that offset predicts a change, and also one edge before and one after. The device model places the word on the data bus for exactly one cycle, the cycle that ends at the expected capture edge. A capture one cycle early or late therefore returns a wrong word. The model also timestamps each command by falling-edge count and compares the spacing with the exact values.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RCD,
    ST_CL,
    ST_RAS
  } state_e;

  localparam int unsigned AP_BIT = 10;
endpackage

// File: rtl/sdram_rd_timer.sv
module sdram_rd_timer #(
  parameter int unsigned CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [W-1:0] cnt_q;

  // load at edge e: done_o rises after edge e+CYCLES-1, so the guarded action lands on edge e+CYCLES
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= W'(CYCLES - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  assert_timer_arms_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && (CYCLES > 1)) |=> !done_o);
endmodule

// File: rtl/sdram_rd_ctrl.sv
module sdram_rd_ctrl
  import sdram_rd_pkg::*;
#(
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned ROW_W   = 12,
  parameter int unsigned COL_W   = 8,
  parameter bit          PRE_ALL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [COL_W-1:0]  req_col_i,
  input  logic              rcd_done_i,
  input  logic              cl_done_i,
  input  logic              ras_done_i,
  input  logic              rp_done_i,
  input  logic              rc_done_i,
  output cmd_e              cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic              ld_act_o,
  output logic              ld_rd_o,
  output logic              ld_pre_o,
  output logic              cap_o,
  output logic              busy_o
);
  timeunit 1ns;
  timeprecision 1ps;

  state_e            st_q, st_d;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic              accept;
  logic [ROW_W-1:0]  rd_addr;
  logic [ROW_W-1:0]  pre_addr;

  // column on the low bits, A10 and above low: no auto-precharge
  always_comb begin
    rd_addr = '0;
    rd_addr[COL_W-1:0] = col_q;
  end

  generate
    if (PRE_ALL) begin : g_pre_all
      assign pre_addr = ROW_W'(1) << AP_BIT;
    end else begin : g_pre_one
      assign pre_addr = '0;
    end
  endgenerate

  assign busy_o = (st_q != ST_IDLE) || !rp_done_i || !rc_done_i;
  assign accept = req_valid_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      bank_q <= '0;
      col_q  <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        bank_q <= req_bank_i;
        col_q  <= req_col_i;
      end
    end
  end

  always_comb begin
    st_d     = st_q;
    cmd_o    = CMD_NOP;
    ba_o     = bank_q;
    addr_o   = '0;
    ld_act_o = 1'b0;
    ld_rd_o  = 1'b0;
    ld_pre_o = 1'b0;
    cap_o    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        cmd_o    = CMD_ACT;
        ba_o     = req_bank_i;
        addr_o   = req_row_i;
        ld_act_o = 1'b1;
        st_d     = ST_RCD;
      end
      ST_RCD: if (rcd_done_i) begin
        cmd_o   = CMD_RD;
        addr_o  = rd_addr;
        ld_rd_o = 1'b1;
        st_d    = ST_CL;
      end
      ST_CL: if (cl_done_i) begin
        cap_o = 1'b1;
        st_d  = ST_RAS;
      end
      ST_RAS: if (ras_done_i) begin
        cmd_o    = CMD_PRE;
        addr_o   = pre_addr;
        ld_pre_o = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assert_busy_after_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);
  assert_one_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> !cap_o);
endmodule

// File: rtl/sdram_rd_pins.sv
module sdram_rd_pins
  import sdram_rd_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned ROW_W  = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [ROW_W-1:0]  addr_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] dq_i,
  output cmd_e              cmd_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  addr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);
  timeunit 1ns;
  timeprecision 1ps;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o   <= CMD_NOP;
      ba_o    <= '0;
      addr_o  <= '0;
      rdata_o <= '0;
      done_o  <= 1'b0;
    end else begin
      cmd_o  <= cmd_i;
      ba_o   <= ba_i;
      addr_o <= addr_i;
      done_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end

  assert_rdata_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(rdata_o));
endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import sdram_rd_pkg::*;
#(
  parameter int unsigned BANK_W  = 2,
  parameter int unsigned ROW_W   = 12,
  parameter int unsigned COL_W   = 8,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned T_RCD   = 2,
  parameter int unsigned T_RP    = 2,
  parameter int unsigned T_RAS   = 6,
  parameter int unsigned T_RC    = 8,
  parameter int unsigned CAS_LAT = 2,
  parameter bit          PRE_ALL = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [BANK_W-1:0]   req_bank_i,
  input  logic [ROW_W-1:0]    req_row_i,
  input  logic [COL_W-1:0]    req_col_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                cke_o,
  output logic                cs_n_o,
  output logic                ras_n_o,
  output logic                cas_n_o,
  output logic                we_n_o,
  output logic [BANK_W-1:0]   ba_o,
  output logic [ROW_W-1:0]    addr_o,
  output logic [DATA_W/8-1:0] dqm_o,
  input  logic [DATA_W-1:0]   dq_i
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned AGE_MAX = T_RC + T_RAS + T_RP + CAS_LAT + T_RCD;
  localparam int unsigned AGE_W   = $clog2(AGE_MAX + 1);

  cmd_e              cmd_d, cmd_q;
  logic [BANK_W-1:0] ba_d;
  logic [ROW_W-1:0]  addr_d;
  logic ld_act, ld_rd, ld_pre, cap;
  logic rcd_done, cl_done, ras_done, rp_done, rc_done;

  sdram_rd_ctrl #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .PRE_ALL(PRE_ALL)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_bank_i (req_bank_i),
    .req_row_i  (req_row_i),
    .req_col_i  (req_col_i),
    .rcd_done_i (rcd_done),
    .cl_done_i  (cl_done),
    .ras_done_i (ras_done),
    .rp_done_i  (rp_done),
    .rc_done_i  (rc_done),
    .cmd_o      (cmd_d),
    .ba_o       (ba_d),
    .addr_o     (addr_d),
    .ld_act_o   (ld_act),
    .ld_rd_o    (ld_rd),
    .ld_pre_o   (ld_pre),
    .cap_o      (cap),
    .busy_o     (busy_o)
  );

  sdram_rd_timer #(.CYCLES(T_RCD)) i_t_rcd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld_act), .done_o(rcd_done));
  sdram_rd_timer #(.CYCLES(T_RAS)) i_t_ras (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld_act), .done_o(ras_done));
  sdram_rd_timer #(.CYCLES(T_RC)) i_t_rc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld_act), .done_o(rc_done));
  // device sees READ one edge after launch, data valid CAS_LAT edges after that
  sdram_rd_timer #(.CYCLES(CAS_LAT + 1)) i_t_cl (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld_rd), .done_o(cl_done));
  sdram_rd_timer #(.CYCLES(T_RP)) i_t_rp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld_pre), .done_o(rp_done));

  sdram_rd_pins #(
    .BANK_W(BANK_W),
    .ROW_W (ROW_W),
    .DATA_W(DATA_W)
  ) i_pins (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd_d),
    .ba_i   (ba_d),
    .addr_i (addr_d),
    .cap_i  (cap),
    .dq_i   (dq_i),
    .cmd_o  (cmd_q),
    .ba_o   (ba_o),
    .addr_o (addr_o),
    .rdata_o(rdata_o),
    .done_o (done_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign cke_o = 1'b1;
  assign dqm_o = '0;

  // edges since the last ACT / PRE appeared on the pins
  logic [AGE_W-1:0] act_age_q, pre_age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_age_q <= AGE_W'(AGE_MAX);
      pre_age_q <= AGE_W'(AGE_MAX);
    end else begin
      if (cmd_q == CMD_ACT)                  act_age_q <= AGE_W'(1);
      else if (act_age_q < AGE_W'(AGE_MAX))  act_age_q <= act_age_q + 1'b1;
      if (cmd_q == CMD_PRE)                  pre_age_q <= AGE_W'(1);
      else if (pre_age_q < AGE_W'(AGE_MAX))  pre_age_q <= pre_age_q + 1'b1;
    end
  end

  assert_read_no_autopre_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RD) |-> (addr_o[AP_BIT] == 1'b0));
  assert_read_after_rcd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_RD) |-> (act_age_q == AGE_W'(T_RCD)));
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_pre_after_tras_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_PRE) |-> (act_age_q >= AGE_W'(T_RAS)));
  assert_act_after_trc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_ACT) |-> (act_age_q >= AGE_W'(T_RC)));
  assert_act_after_trp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_ACT) |-> (pre_age_q >= AGE_W'(T_RP)));
  assert_no_act_when_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (cmd_q != CMD_ACT));
  assert_legal_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_q inside {CMD_NOP, CMD_ACT, CMD_RD, CMD_PRE});
endmodule

// File: tb/test_sdram_rd_seq.sv
module test_sdram_rd_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TRCD = 2, TRP = 2, TRAS = 6, TRC = 8, CL = 2;
  localparam int DONE_AT = TRCD + CL + 2;  // falling edge after the request where done_o shows
  localparam int PRE_OFF = (TRCD + CL + 2 > TRAS) ? TRCD + CL + 2 : TRAS;
  localparam int IDLE_AT = (PRE_OFF + TRP > TRC) ? PRE_OFF + TRP : TRC;

  logic        clk, rst_n;
  logic        req_valid;
  logic [1:0]  req_bank;
  logic [11:0] req_row;
  logic [7:0]  req_col;
  logic        busy, done, cke, cs_n, ras_n, cas_n, we_n;
  logic [15:0] rdata, dq;
  logic [1:0]  ba, dqm;
  logic [11:0] addr;

  sdram_rd_seq i_sdram_rd_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_bank_i(req_bank),
    .req_row_i(req_row), .req_col_i(req_col), .busy_o(busy), .done_o(done),
    .rdata_o(rdata), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .ba_o(ba), .addr_o(addr), .dqm_o(dqm), .dq_i(dq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int errs = 0, nchk = 0;
  bit fin = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] word_of(logic [1:0] b, logic [11:0] r, logic [7:0] c);
    return {b, r, 2'b00} ^ {c, c} ^ 16'h5A3C;
  endfunction

  // device model, one tick per falling edge
  int tick = 0, last_act = -1000, last_pre = -1000, rd_tick = -1000;
  int act_cnt = 0, act_gap = 0;
  logic [1:0]  m_bank = '0, exp_bank = '0;
  logic [11:0] m_row = '0, exp_row = '0;
  logic [7:0]  exp_col = '0;
  logic [15:0] rd_val = '0;
  logic [3:0]  m_cmd;

  initial dq = 16'hDEAD;

  always @(negedge clk) begin
    if (rst_n) begin
      tick++;
      m_cmd = {cs_n, ras_n, cas_n, we_n};
      case (m_cmd)
        4'b0111: ;
        4'b0011: begin
          act_gap = tick - last_act;
          check(tick - last_act >= TRC, "R6", "act-to-act gap", tick - last_act, TRC);
          check(tick - last_pre >= TRP, "R6", "pre-to-act gap", tick - last_pre, TRP);
          check(ba == exp_bank && addr == exp_row, "R2", "act bank/row",
                {ba, addr}, {exp_bank, exp_row});
          m_bank = ba; m_row = addr; last_act = tick; act_cnt++;
        end
        4'b0101: begin
          check(tick - last_act == TRCD, "R3", "act-to-read gap", tick - last_act, TRCD);
          check(ba == m_bank && addr[7:0] == exp_col && addr[11:8] == 4'h0, "R3",
                "read bank/addr", {ba, addr}, {m_bank, 4'h0, exp_col});
          rd_val = word_of(m_bank, m_row, addr[7:0]);
          rd_tick = tick;
        end
        4'b0010: begin
          check(tick - last_act == PRE_OFF, "R5", "act-to-pre gap", tick - last_act, PRE_OFF);
          check(ba == m_bank && addr[10] == 1'b0, "R5", "pre bank/a10",
                {ba, addr[10]}, {m_bank, 1'b0});
          last_pre = tick;
        end
        default: check(1'b0, "R8", "illegal command", m_cmd, 4'b0111);
      endcase
      if (tick == rd_tick + CL)          dq = rd_val;
      else if (tick == rd_tick + CL + 1) dq = 16'hDEAD;
    end
  end

  task automatic wait_idle();
    for (int g = 0; g < 100 && busy; g++) @(negedge clk);
  endtask

  task automatic tx(input logic [1:0] b, input logic [11:0] r, input logic [7:0] c,
                    input bit inj);
    int a0;
    logic [15:0] w;
    wait_idle();
    a0 = act_cnt;
    w = word_of(b, r, c);
    exp_bank = b; exp_row = r; exp_col = c;
    req_valid = 1'b1; req_bank = b; req_row = r; req_col = c;
    for (int n = 1; n <= IDLE_AT + 1; n++) begin
      @(negedge clk);
      if (n == 1) begin
        req_valid = 1'b0;
        check(busy == 1'b1, "R7", "busy after accept", busy, 1);
      end
      if (inj && n == 2) begin
        req_valid = 1'b1; req_bank = ~b; req_row = ~r; req_col = ~c;
      end
      if (inj && n == 3) req_valid = 1'b0;
      if (n == IDLE_AT - 1) check(busy == 1'b1, "R7", "busy before slot", busy, 1);
      if (n == IDLE_AT)     check(busy == 1'b0, "R7", "busy at slot", busy, 0);
      if (n == DONE_AT - 1) check(done == 1'b0, "R4", "done early", done, 0);
      if (n == DONE_AT) begin
        check(done == 1'b1, "R4", "done on time", done, 1);
        check(rdata == w, "R4", "read word", rdata, w);
      end
      if (n == DONE_AT + 1) begin
        check(done == 1'b0, "R4", "done width", done, 0);
        check(rdata == w, "R4", "word held", rdata, w);
      end
    end
    check(act_cnt - a0 == 1, inj ? "R7" : "R2", "activates per request", act_cnt - a0, 1);
  endtask

  initial begin
    int a0;
    logic [11:0] r;
    logic [7:0]  c;
    rst_n = 1'b0; req_valid = 1'b0; req_bank = '0; req_row = '0; req_col = '0;
    repeat (3) @(negedge clk);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", "cmd in reset",
          {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    check(cke == 1'b1 && dqm == 2'b00, "R1", "cke/dqm in reset", {cke, dqm}, 3'b100);
    check(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R8", "idle nop",
          {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);

    for (int b = 0; b < 4; b++)
      for (int ri = 0; ri < 3; ri++)
        for (int ci = 0; ci < 4; ci++) begin
          r = (ri == 0) ? 12'h000 : (ri == 1) ? 12'hFFF : 12'((b * 977 + ri * 131) % 4096);
          c = (ci == 0) ? 8'h00 : (ci == 1) ? 8'hFF : 8'((b * 37 + ci * 91 + ri * 13) % 256);
          tx(2'(b), r, c, 1'b0);
          check(cke == 1'b1 && dqm == 2'b00, "R1", "cke/dqm steady", {cke, dqm}, 3'b100);
        end

    // request while busy must be dropped (R7)
    tx(2'd2, 12'h123, 8'h45, 1'b1);

    // valid held high: activates at the full cycle rate (R6)
    wait_idle();
    exp_bank = 2'd1; exp_row = 12'h3C3; exp_col = 8'h99;
    a0 = act_cnt;
    req_valid = 1'b1; req_bank = 2'd1; req_row = 12'h3C3; req_col = 8'h99;
    repeat (3 * IDLE_AT) @(negedge clk);
    req_valid = 1'b0;
    repeat (IDLE_AT + 2) @(negedge clk);
    check(act_cnt - a0 == 3, "R6", "activates in window", act_cnt - a0, 3);
    check(act_gap == IDLE_AT, "R6", "back-to-back spacing", act_gap, IDLE_AT);
    check(rdata == word_of(2'd1, 12'h3C3, 8'h99), "R4", "streamed word",
          rdata, word_of(2'd1, 12'h3C3, 8'h99));
    check(busy == 1'b0 && done == 1'b0, "R7", "quiet at end", {busy, done}, 0);

    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      nchk++;
      errs++;
      $display("FAIL R4 watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end
endmodule